// File: doc/BRIEF.md
# DVS Speed Transition Controller

This block moves a variable-voltage processor between a small set of discrete speed settings. Each setting is one integer multiple of a fixed external reference clock, and it carries exactly one supply code: the lowest supply that still meets timing at that multiple. A higher setting always needs an equal or higher supply code. When a new setting is requested, the controller orders the changes to the supply regulator and to the PLL. It times how long each one takes to settle and tells the core whether it must halt.

Two transition styles can be chosen for each request. In halting style, the supply code and the multiplier change together and the core is stalled until both have settled. The time taken is the longer of the two settle times. In run-through style, the core keeps executing while the supply ramps, at whichever frequency the lower of the two supplies permits. It is stalled only while the PLL relocks. Going up, the supply is raised before the multiplier. Going down, the multiplier drops before the supply. Settle times are cycle counts supplied with each request. The analog regulator and the PLL are not modelled beyond these counts.

Top module: `dvs_speed_ctrl`

## Requirements
- R1: After reset, `cur_idx` equals RESET_IDX, `pll_mult` and `vcode` hold that setting's values, and `busy`, `stall` and `done` are low.
- R2: Setting i maps to multiplier MULT_BASE + MULT_STEP*i and supply code VC_BASE + VC_STEP*i. When no transition is running, both outputs show the values of `cur_idx`.
- R3: In halting style (`run_through` = 0), an accepted request changes `vcode` and `pll_mult` together in the cycle after acceptance. `busy` and `stall` are then high for exactly max(Ve, Pe) cycles, where Ve = max(`v_settle`,1) and Pe = max(`p_settle`,1).
- R4: In run-through style, a request for a higher index first raises `vcode` for Ve cycles. During those cycles `pll_mult` keeps its old value and `stall` is low. Then `pll_mult` changes and `stall` is high for Pe cycles.
- R5: In run-through style, a request for a lower index first lowers `pll_mult` with `stall` high for Pe cycles. Then `vcode` is lowered for Ve cycles with `stall` low.
- R6: Whenever `stall` is low, `vcode` is at least the supply code required by the current `pll_mult`.
- R7: `done` is high for exactly one cycle, the first cycle after `busy` falls. In that cycle `cur_idx` shows the new setting.
- R8: A valid request that arrives while `busy` is high is held in a single slot, and a later request overwrites it. The held request is accepted in the cycle after `done`, using the `run_through`, `v_settle` and `p_settle` values of that cycle.
- R9: A request for the current `cur_idx`, or for an index of NUM_SPEEDS or above, is ignored: `busy` stays low and the outputs do not change.
- R10: The style and the settle counts are sampled only when a request is accepted. Changing them during a transition has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Speed change request strobe |
| req_idx | input | IDX_W | Requested speed index |
| run_through | input | 1 | 1: run-through style, 0: halting style |
| v_settle | input | TMR_W | Supply settle time in cycles (0 is treated as 1) |
| p_settle | input | TMR_W | PLL relock time in cycles (0 is treated as 1) |
| vcode | output | VC_W | Supply code driven to the regulator |
| pll_mult | output | MULT_W | Multiplier driven to the PLL |
| stall | output | 1 | Core halt request |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_idx | output | IDX_W | Settled speed index |

## Verification
The bench builds the block with NUM_SPEEDS = 6 while IDX_W stays 3. This makes indexes 6 and 7 reachable, so the out-of-range rule can be exercised. TMR_W is set to 8 and settle counts are drawn from 0 to 9. This keeps each transition short enough for many random up and down steps in both styles. It also hits the zero-count clamp and both cases where either settle time is the longer one.

// File: rtl/dvs_speed_pkg.sv
package dvs_speed_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BOTH = 3'd1,
    ST_VUP  = 3'd2,
    ST_PUP  = 3'd3,
    ST_PDN  = 3'd4,
    ST_VDN  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dvs_speed_table.sv
module dvs_speed_table #(
  parameter int IDX_W     = 3,
  parameter int MULT_W    = 8,
  parameter int VC_W      = 8,
  parameter int MULT_BASE = 4,
  parameter int MULT_STEP = 2,
  parameter int VC_BASE   = 12,
  parameter int VC_STEP   = 5
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [MULT_W-1:0] mult,
  output logic [VC_W-1:0]   vcode
);
  always_comb begin
    mult  = MULT_W'(MULT_BASE + MULT_STEP * int'(idx));
    vcode = VC_W'(VC_BASE + VC_STEP * int'(idx));
  end
endmodule

// File: rtl/dvs_settle_timer.sv
module dvs_settle_timer #(
  parameter int TMR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [TMR_W-1:0] load_val,
  output logic             last
);
  logic [TMR_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load_en) begin
      rem_d = (load_val == '0) ? {{(TMR_W-1){1'b0}}, 1'b1} : load_val;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign last = (rem_q[TMR_W-1:1] == '0);
endmodule

// File: rtl/dvs_pending_req.sv
module dvs_pending_req #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic             clear,
  output logic             pend_valid,
  output logic [IDX_W-1:0] pend_idx
);
  logic             vld_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    vld_d = pend_valid;
    idx_d = pend_idx;
    if (capture) begin
      vld_d = 1'b1;
      idx_d = cap_idx;
    end else if (clear) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_idx   <= '0;
    end else begin
      pend_valid <= vld_d;
      pend_idx   <= idx_d;
    end
  end
endmodule

// File: rtl/dvs_speed_ctrl.sv
module dvs_speed_ctrl
  import dvs_speed_pkg::*;
#(
  parameter int NUM_SPEEDS = 8,
  parameter int IDX_W      = (NUM_SPEEDS > 1) ? $clog2(NUM_SPEEDS) : 1,
  parameter int MULT_W     = 8,
  parameter int VC_W       = 8,
  parameter int TMR_W      = 18,
  parameter int MULT_BASE  = 4,
  parameter int MULT_STEP  = 2,
  parameter int VC_BASE    = 12,
  parameter int VC_STEP    = 5,
  parameter int RESET_IDX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              run_through,
  input  logic [TMR_W-1:0]  v_settle,
  input  logic [TMR_W-1:0]  p_settle,
  output logic [VC_W-1:0]   vcode,
  output logic [MULT_W-1:0] pll_mult,
  output logic              stall,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  cur_idx
);
  localparam logic [IDX_W-1:0] RST_IDX = IDX_W'(RESET_IDX);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] v_idx_q, v_idx_d;
  logic [IDX_W-1:0] f_idx_q, f_idx_d;
  logic [IDX_W-1:0] tgt_q, tgt_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [TMR_W-1:0] vset_q, vset_d, pset_q, pset_d;
  logic             done_q, done_d;

  logic             vt_load, pt_load, vt_last, pt_last;
  logic [TMR_W-1:0] vt_val, pt_val;
  logic             pend_valid, pend_clear, pend_cap;
  logic [IDX_W-1:0] pend_idx;
  logic             cand_has;
  logic [IDX_W-1:0] cand_idx;
  logic             req_ok;

  logic [MULT_W-1:0] unused_vmult;
  logic [VC_W-1:0]   unused_fvc;

  dvs_speed_table #(
    .IDX_W(IDX_W), .MULT_W(MULT_W), .VC_W(VC_W),
    .MULT_BASE(MULT_BASE), .MULT_STEP(MULT_STEP),
    .VC_BASE(VC_BASE), .VC_STEP(VC_STEP)
  ) u_vtab (.idx(v_idx_q), .mult(unused_vmult), .vcode(vcode));

  dvs_speed_table #(
    .IDX_W(IDX_W), .MULT_W(MULT_W), .VC_W(VC_W),
    .MULT_BASE(MULT_BASE), .MULT_STEP(MULT_STEP),
    .VC_BASE(VC_BASE), .VC_STEP(VC_STEP)
  ) u_ftab (.idx(f_idx_q), .mult(pll_mult), .vcode(unused_fvc));

  dvs_settle_timer #(.TMR_W(TMR_W)) u_vtmr (
    .clk(clk), .rst_n(rst_n), .load_en(vt_load), .load_val(vt_val), .last(vt_last)
  );

  dvs_settle_timer #(.TMR_W(TMR_W)) u_ptmr (
    .clk(clk), .rst_n(rst_n), .load_en(pt_load), .load_val(pt_val), .last(pt_last)
  );

  assign req_ok   = req_valid && (int'(req_idx) < NUM_SPEEDS);
  assign busy     = (state_q != ST_IDLE);
  assign pend_cap = busy && req_ok;

  dvs_pending_req #(.IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .capture(pend_cap), .cap_idx(req_idx),
    .clear(pend_clear), .pend_valid(pend_valid), .pend_idx(pend_idx)
  );

  // A fresh request in an idle cycle takes precedence over the held one.
  always_comb begin
    cand_has = 1'b0;
    cand_idx = pend_idx;
    if (req_ok) begin
      cand_has = 1'b1;
      cand_idx = req_idx;
    end else if (pend_valid) begin
      cand_has = 1'b1;
    end
  end

  always_comb begin
    state_d    = state_q;
    v_idx_d    = v_idx_q;
    f_idx_d    = f_idx_q;
    tgt_d      = tgt_q;
    cur_d      = cur_q;
    vset_d     = vset_q;
    pset_d     = pset_q;
    done_d     = 1'b0;
    vt_load    = 1'b0;
    pt_load    = 1'b0;
    vt_val     = v_settle;
    pt_val     = p_settle;
    pend_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        pend_clear = pend_valid;
        if (cand_has && (cand_idx != cur_q)) begin
          tgt_d  = cand_idx;
          vset_d = v_settle;
          pset_d = p_settle;
          if (!run_through) begin
            v_idx_d = cand_idx;
            f_idx_d = cand_idx;
            vt_load = 1'b1;
            pt_load = 1'b1;
            state_d = ST_BOTH;
          end else if (cand_idx > cur_q) begin
            v_idx_d = cand_idx;
            vt_load = 1'b1;
            state_d = ST_VUP;
          end else begin
            f_idx_d = cand_idx;
            pt_load = 1'b1;
            state_d = ST_PDN;
          end
        end
      end
      ST_BOTH: begin
        if (vt_last && pt_last) begin
          cur_d   = tgt_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_VUP: begin
        if (vt_last) begin
          f_idx_d = tgt_q;
          pt_load = 1'b1;
          pt_val  = pset_q;
          state_d = ST_PUP;
        end
      end
      ST_PDN: begin
        if (pt_last) begin
          v_idx_d = tgt_q;
          vt_load = 1'b1;
          vt_val  = vset_q;
          state_d = ST_VDN;
        end
      end
      ST_PUP, ST_VDN: begin
        if ((state_q == ST_PUP) ? pt_last : vt_last) begin
          cur_d   = tgt_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      v_idx_q <= RST_IDX;
      f_idx_q <= RST_IDX;
      tgt_q   <= RST_IDX;
      cur_q   <= RST_IDX;
      vset_q  <= '0;
      pset_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      v_idx_q <= v_idx_d;
      f_idx_q <= f_idx_d;
      tgt_q   <= tgt_d;
      cur_q   <= cur_d;
      vset_q  <= vset_d;
      pset_q  <= pset_d;
      done_q  <= done_d;
    end
  end

  assign stall   = (state_q == ST_BOTH) || (state_q == ST_PUP) || (state_q == ST_PDN);
  assign done    = done_q;
  assign cur_idx = cur_q;
endmodule

// File: rtl/dvs_speed_ctrl_chk.sv
module dvs_speed_ctrl_chk #(
  parameter int IDX_W  = 3,
  parameter int MULT_W = 8,
  parameter int VC_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              stall,
  input logic              done,
  input logic [VC_W-1:0]   vcode,
  input logic [MULT_W-1:0] pll_mult,
  input logic [IDX_W-1:0]  v_idx,
  input logic [IDX_W-1:0]  f_idx
);
  // R6: the supply setting covers the clock whenever the core runs
  assert_supply_covers_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (v_idx >= f_idx));

  // R7: completion pulse accompanies the fall of busy
  assert_done_on_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: completion pulse lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: no stall outside a transition
  assert_no_idle_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);

  // R9: outputs to regulator and PLL move only inside a transition
  assert_mult_moves_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_mult) |-> busy);

  assert_vcode_moves_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcode) |-> busy);
endmodule

bind dvs_speed_ctrl dvs_speed_ctrl_chk #(
  .IDX_W(IDX_W), .MULT_W(MULT_W), .VC_W(VC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .stall(stall), .done(done),
  .vcode(vcode), .pll_mult(pll_mult), .v_idx(v_idx_q), .f_idx(f_idx_q)
);

// File: tb/dvs_speed_ctrl_tb.sv
module dvs_speed_ctrl_tb;
  localparam int NS    = 6;
  localparam int IW    = 3;
  localparam int TW    = 8;
  localparam int MW    = 8;
  localparam int VW    = 8;

  logic          clk, rst_n;
  logic          req_valid;
  logic [IW-1:0] req_idx;
  logic          run_through;
  logic [TW-1:0] v_settle, p_settle;
  logic [VW-1:0] vcode;
  logic [MW-1:0] pll_mult;
  logic          stall, busy, done;
  logic [IW-1:0] cur_idx;

  int checks, fails, cyc, cur_i;

  dvs_speed_ctrl #(
    .NUM_SPEEDS(NS), .IDX_W(IW), .MULT_W(MW), .VC_W(VW), .TMR_W(TW),
    .MULT_BASE(4), .MULT_STEP(2), .VC_BASE(12), .VC_STEP(5), .RESET_IDX(0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .run_through(run_through), .v_settle(v_settle), .p_settle(p_settle),
    .vcode(vcode), .pll_mult(pll_mult), .stall(stall), .busy(busy),
    .done(done), .cur_idx(cur_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int em(int i); return 4 + 2 * i; endfunction
  function automatic int ev(int i); return 12 + 5 * i; endfunction
  function automatic int eff(int n); return (n == 0) ? 1 : n; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // expected outputs for one busy cycle
  task automatic cyc_chk(input string tag, input int ev_i, input int em_i, input bit es);
    chk(busy == 1'b1, {tag, " busy"}, busy, 1);
    chk(int'(vcode) == ev(ev_i) && int'(pll_mult) == em(em_i) && stall == es,
        {tag, " outputs"}, int'(vcode) * 1000 + int'(pll_mult) * 10 + stall,
        ev(ev_i) * 1000 + em(em_i) * 10 + es);
    if (!stall) chk(int'(vcode) >= ev((int'(pll_mult) - 4) / 2), "R6 supply covers clock",
                    int'(vcode), ev((int'(pll_mult) - 4) / 2));
  endtask

  task automatic do_trans(input int ni, input bit rt, input int vs, input int ps);
    int ve, pe, m;
    string tg;
    ve = eff(vs); pe = eff(ps); m = (ve > pe) ? ve : pe;
    tg = !rt ? "R3" : (ni > cur_i) ? "R4" : "R5";
    @(negedge clk);
    req_valid = 1'b1; req_idx = IW'(ni); run_through = rt;
    v_settle = TW'(vs); p_settle = TW'(ps);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: perturb sampled inputs after acceptance
    run_through = ~rt; v_settle = TW'($urandom_range(1, 30)); p_settle = TW'($urandom_range(1, 30));
    if (!rt) begin
      for (int j = 0; j < m; j++) begin
        if (j > 0) @(negedge clk);
        cyc_chk(tg, ni, ni, 1'b1);
      end
    end else if (ni > cur_i) begin
      for (int j = 0; j < ve + pe; j++) begin
        if (j > 0) @(negedge clk);
        if (j < ve) cyc_chk({tg, " R10"}, ni, cur_i, 1'b0);
        else        cyc_chk({tg, " R10"}, ni, ni, 1'b1);
      end
    end else begin
      for (int j = 0; j < ve + pe; j++) begin
        if (j > 0) @(negedge clk);
        if (j < pe) cyc_chk({tg, " R10"}, cur_i, ni, 1'b1);
        else        cyc_chk({tg, " R10"}, ni, ni, 1'b0);
      end
    end
    @(negedge clk);
    chk(busy == 1'b0 && stall == 1'b0, "R7 busy end", busy, 0);
    chk(done == 1'b1, "R7 done pulse", done, 1);
    chk(int'(cur_idx) == ni, "R7 cur_idx", int'(cur_idx), ni);
    chk(int'(vcode) == ev(ni) && int'(pll_mult) == em(ni), "R2 settled map",
        int'(vcode) * 1000 + int'(pll_mult), ev(ni) * 1000 + em(ni));
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    cur_i = ni;
  endtask

  task automatic ignore_chk(input int ni);
    @(negedge clk);
    req_valid = 1'b1; req_idx = IW'(ni); run_through = 1'b0;
    v_settle = 8'd3; p_settle = 8'd3;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 0; j < 3; j++) begin
      chk(busy == 1'b0 && done == 1'b0, "R9 ignored request", busy, 0);
      chk(int'(cur_idx) == cur_i && int'(vcode) == ev(cur_i) && int'(pll_mult) == em(cur_i),
          "R9 outputs unchanged", int'(cur_idx), cur_i);
      @(negedge clk);
    end
  endtask

  initial begin
    int guard, ni;
    checks = 0; fails = 0; cyc = 0; cur_i = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_idx = '0; run_through = 1'b0;
    v_settle = '0; p_settle = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(cur_idx) == 0 && busy == 0 && stall == 0 && done == 0, "R1 reset flags",
        int'(cur_idx) * 1000 + busy * 100 + stall * 10 + done, 0);
    chk(int'(vcode) == ev(0) && int'(pll_mult) == em(0), "R1 reset setting",
        int'(vcode) * 1000 + int'(pll_mult), ev(0) * 1000 + em(0));

    do_trans(3, 1'b0, 5, 2);   // R3 supply longer
    do_trans(5, 1'b0, 2, 7);   // R3 PLL longer
    do_trans(2, 1'b0, 0, 0);   // R3 zero counts clamp to one
    do_trans(4, 1'b1, 3, 2);   // R4
    do_trans(1, 1'b1, 3, 4);   // R5
    do_trans(2, 1'b1, 0, 0);   // R4 zero counts
    ignore_chk(cur_i);         // R9 same index
    ignore_chk(7);             // R9 out of range

    // R8: held request, latest wins
    @(negedge clk);
    req_valid = 1'b1; req_idx = 3'd4; run_through = 1'b0; v_settle = 8'd3; p_settle = 8'd3;
    @(posedge clk); @(negedge clk);
    req_idx = 3'd0;
    @(posedge clk); @(negedge clk);
    req_idx = 3'd5;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; run_through = 1'b0; v_settle = 8'd2; p_settle = 8'd2;
    guard = 0;
    while (!done && guard < 20) begin @(negedge clk); guard++; end
    chk(int'(cur_idx) == 4, "R8 first request completes", int'(cur_idx), 4);
    @(negedge clk);
    chk(busy == 1'b1 && stall == 1'b1 && int'(pll_mult) == em(5), "R8 held request starts",
        int'(pll_mult), em(5));
    guard = 0;
    while (!done && guard < 20) begin @(negedge clk); guard++; end
    chk(int'(cur_idx) == 5 && int'(vcode) == ev(5), "R8 latest held wins", int'(cur_idx), 5);
    cur_i = 5;
    @(negedge clk);

    for (int k = 0; k < 40; k++) begin
      ni = $urandom_range(0, NS - 1);
      if (ni == cur_i) ni = (ni + 1) % NS;
      do_trans(ni, 1'($urandom_range(0, 1)), $urandom_range(0, 9), $urandom_range(0, 9));
    end

    summary();
    $finish;
  end
endmodule